// File: doc/BRIEF.md
# Ratiometric Sigma-Delta Calibration Sequencer

This block sits next to a synchronous, first-order sigma-delta modulator and turns its one-bit output into a calibrated conversion word. It drives a 3-bit source-select code to the modulator, and measures three sources in turn: the ground reference, the input pin and the supply reference. For each source it stops and restarts the modulator and throws away a settling stretch. It then counts the ones in a measurement window. The input reading is then expressed as a fraction of the span between the two references, so the modulator's own gain and offset drop out.

Each fraction is ((pin - ground) << 32) / (supply - ground), shifted right by 8 into a 24-bit value. A power-of-two number of fractions is summed and divided down into one output word. A single start pulse, typically from a slow timer, begins a word, and the block is otherwise idle. A second ordering is available in which the input is measured every other window between alternating ground and supply readings. Each input window is then paired with the reference windows on either side of it.

The settling length, window length, average count, gain code and ordering are taken from the ports when the start pulse is accepted. They are held for the whole word.

Top module: `rsd_cal_seq`

## Requirements
- R1: After reset the block is idle: src_sel is 000, mod_en is 0, result_valid is 0, and result and result_err are 0. It stays idle until start is sampled high.
- R2: In normal ordering (interleave=0) each fraction measures ground (src_sel 000), then the input, then the supply (src_sel 001). 2^avg_log2 fractions make one word.
- R3: Every source window starts with one clock in which src_sel already shows the new source and mod_en is 0. It then holds mod_en at 1 for settle_len clocks, whose bits are not counted, and then for window_len clocks, whose ones are counted. settle_len and window_len must be at least 1.
- R4: While the input is measured, src_sel equals gain_code when gain_code is 011 to 111 (011 = unity, 100 to 111 = increasing gain). It equals 011 when gain_code is 000 to 010.
- R5: Each fraction is (((pin - ground) << 32) / (supply - ground)) >> 8, computed on the window counts. It saturates to 0xFFFFFF when larger, and it is 0 when pin is below ground.
- R6: When supply minus ground is zero or negative, that fraction is 0xFFFFFF, and result_err is 1 for the word that contains it.
- R7: result is the floor of the sum of the word's fractions divided by 2^avg_log2.
- R8: After a window that completes a fraction, mod_en stays 0 for CNT_W+35 clocks. The next source window or result_valid follows at once.
- R9: result_valid is high for exactly one clock per word, in the clock after the last fraction's computation. result and result_err do not change at other times.
- R10: In interleaved ordering (interleave=1) a word starts with ground and then repeats input, supply, input, ground. A fraction is formed after every reference window except the first, from the last input window and the reference windows just before and after it.
- R11: start, gain_code, interleave, settle_len, window_len and avg_log2 have no effect while a word is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a word when the block is idle |
| sd_bit | input | 1 | Modulator output bit, one per clock |
| gain_code | input | 3 | Select code used for the input source |
| interleave | input | 1 | 1 selects interleaved ordering |
| settle_len | input | CNT_W | Clocks discarded after each source switch |
| window_len | input | CNT_W | Clocks counted per source window |
| avg_log2 | input | AVG_LW | log2 of the fractions averaged per word |
| src_sel | output | 3 | Source-select code to the modulator |
| mod_en | output | 1 | Modulator run enable |
| result | output | 24 | Averaged normalized word |
| result_err | output | 1 | Reference span was not positive in this word |
| result_valid | output | 1 | One-clock strobe when result updates |

## Verification
The hardest condition to reach from the ports is a held start and a changed configuration in the middle of a word. The test has to show that neither one changes the source order, the window lengths or the result. The bench reaches it by raising start and rewriting every configuration input right after the first source switch. It keeps them that way until just before the last fraction is computed. A model that runs on every clock, driven by the settings latched at the start of the word, has to predict the select code and enable throughout. The reference spans that are inverted or zero, and the saturating ratios, are produced by setting the bench's bit-source densities so that ground lies above supply, or the input lies above supply or below ground.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  typedef enum logic [1:0] {SRC_GND, SRC_PIN, SRC_SUP} src_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_LOAD, ST_WAIT, ST_ACC} st_e;
  typedef enum logic [1:0] {W_OFF, W_GAP, W_SET, W_MEAS} wph_e;

  localparam logic [2:0] SEL_GND  = 3'b000;
  localparam logic [2:0] SEL_SUP  = 3'b001;
  localparam logic [2:0] SEL_UNIT = 3'b011;

  // Input-source code: gain codes below unity fall back to unity.
  function automatic logic [2:0] pin_select(input logic [2:0] g);
    return (g >= SEL_UNIT) ? g : SEL_UNIT;
  endfunction

  function automatic logic [2:0] src_code(input src_e s, input logic [2:0] pin_code);
    case (s)
      SRC_GND: return SEL_GND;
      SRC_SUP: return SEL_SUP;
      default: return pin_code;
    endcase
  endfunction

  // Ordering: normal G,P,S,G...; interleaved G,P,S,P,G,P,S...
  function automatic src_e next_source(input src_e cur, input logic ilv, input logic ref_was_gnd);
    if (!ilv) begin
      case (cur)
        SRC_GND: return SRC_PIN;
        SRC_PIN: return SRC_SUP;
        default: return SRC_GND;
      endcase
    end
    if (cur != SRC_PIN) return SRC_PIN;
    return ref_was_gnd ? SRC_SUP : SRC_GND;
  endfunction

endpackage

// File: rtl/rsd_window.sv
module rsd_window
  import rsd_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] settle,
  input  logic [CW-1:0] window,
  input  logic          bit_in,
  output logic          running,
  output logic          done,
  output logic [CW-1:0] ones_final
);

  wph_e          phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] ones;

  assign running    = (phase == W_SET) || (phase == W_MEAS);
  assign done       = (phase == W_MEAS) && (cnt == '0);
  assign ones_final = ones + CW'(bit_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= W_OFF;
      cnt   <= '0;
      ones  <= '0;
    end else if (go) begin
      phase <= W_GAP;
      ones  <= '0;
    end else begin
      case (phase)
        W_GAP: begin
          phase <= W_SET;
          cnt   <= settle - CW'(1);
        end
        W_SET: begin
          if (cnt == '0) begin
            phase <= W_MEAS;
            cnt   <= window - CW'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        W_MEAS: begin
          ones <= ones + CW'(bit_in);
          if (cnt == '0) phase <= W_OFF;
          else           cnt   <= cnt - CW'(1);
        end
        default: phase <= W_OFF;
      endcase
    end
  end

  // R3: a window never holds more ones than its length
  a_r3_ones_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == W_MEAS) |-> (ones <= window));

  // R3: the settle stretch always hands over to a measurement stretch
  a_r3_settle_then_meas: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == W_SET && cnt == '0 && !go) |=> (phase == W_MEAS));

endmodule

// File: rtl/rsd_divider.sv
module rsd_divider #(
  parameter int NW = 52,
  parameter int VW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quotient
);

  localparam int CTW = $clog2(NW + 1);

  logic           busy;
  logic [CTW-1:0] cnt;
  logic [NW-1:0]  dvd;
  logic [VW-1:0]  dvs;
  logic [VW-1:0]  rem;
  logic [VW:0]    trial;
  logic           fits;

  assign trial    = {rem, dvd[NW-1]};
  assign fits     = trial >= {1'b0, dvs};
  assign done     = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      dvd      <= '0;
      dvs      <= '0;
      rem      <= '0;
      quotient <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cnt      <= CTW'(NW);
      dvd      <= dividend;
      dvs      <= divisor;
      rem      <= '0;
      quotient <= '0;
    end else if (busy) begin
      if (cnt != '0) begin
        rem      <= fits ? VW'(trial - {1'b0, dvs}) : trial[VW-1:0];
        quotient <= {quotient[NW-2:0], fits};
        dvd      <= dvd << 1;
        cnt      <= cnt - CTW'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end

  // R5: restoring step keeps the partial remainder below the divisor
  a_r5_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < dvs));

  // R8: completion is a single-clock event
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/rsd_avg.sv
module rsd_avg #(
  parameter int OW = 24,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic          last,
  input  logic [OW-1:0] value,
  input  logic          value_err,
  input  logic [LW-1:0] log2,
  output logic [OW-1:0] result,
  output logic          err,
  output logic          valid
);

  localparam int SW = OW + (1 << LW) - 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] total;
  logic          err_acc;

  assign total = sum + SW'(value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum     <= '0;
      err_acc <= 1'b0;
      result  <= '0;
      err     <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clr) begin
        sum     <= '0;
        err_acc <= 1'b0;
      end else if (add) begin
        if (last) begin
          result <= OW'(total >> log2);
          err    <= err_acc | value_err;
          valid  <= 1'b1;
        end else begin
          sum     <= total;
          err_acc <= err_acc | value_err;
        end
      end
    end
  end

  // R9: strobe lasts one clock
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R9: word and flag only move together with the strobe
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(result) && $stable(err)));

endmodule

// File: rtl/rsd_cal_seq.sv
module rsd_cal_seq
  import rsd_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int AVG_LW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sd_bit,
  input  logic [2:0]        gain_code,
  input  logic              interleave,
  input  logic [CNT_W-1:0]  settle_len,
  input  logic [CNT_W-1:0]  window_len,
  input  logic [AVG_LW-1:0] avg_log2,
  output logic [2:0]        src_sel,
  output logic              mod_en,
  output logic [23:0]       result,
  output logic              result_err,
  output logic              result_valid
);

  localparam int FRAC_SHIFT = 32;
  localparam int DROP       = 8;
  localparam int OUT_W      = FRAC_SHIFT - DROP;
  localparam int DW         = CNT_W + FRAC_SHIFT;
  localparam int FCW        = 1 << AVG_LW;

  st_e               state;
  src_e              src;
  src_e              src_nxt;
  logic              ref_was_gnd;
  logic              pin_seen;
  logic [CNT_W-1:0]  cnt_g, cnt_p, cnt_s;
  logic [FCW-1:0]    frac_cnt;
  logic [FCW-1:0]    frac_goal;
  logic [CNT_W-1:0]  settle_r, win_r;
  logic [AVG_LW-1:0] avg_r;
  logic [2:0]        gain_r;
  logic              ilv_r;
  logic              neg_r, bad_r;

  // Named internal events used by the assertions below.
  logic              win_done;
  logic              calc_due;
  logic              last_frac;
  logic              win_go;
  logic              div_done;
  logic [CNT_W-1:0]  ones_final;
  logic [CNT_W:0]    diff, span;
  logic              diff_neg, span_bad;
  logic [DW-1:0]     div_num;
  logic [CNT_W-1:0]  div_den;
  logic [DW-1:0]     quotient;
  logic [OUT_W-1:0]  norm;
  logic [OUT_W-1:0]  avg_word;

  function automatic logic [OUT_W-1:0] norm_of(input logic [DW-1:0] q, input logic neg,
                                               input logic bad);
    if (bad)                  return '1;
    if (neg)                  return '0;
    if (|q[DW-1:FRAC_SHIFT])  return '1;
    return q[FRAC_SHIFT-1:DROP];
  endfunction

  assign src_nxt   = next_source(src, ilv_r, ref_was_gnd);
  assign calc_due  = win_done && (src != SRC_PIN) && pin_seen;
  assign frac_goal = (FCW'(1) << avg_r) - FCW'(1);
  assign last_frac = (frac_cnt == frac_goal);
  assign win_go    = ((state == ST_IDLE) && start)
                   || ((state == ST_RUN) && win_done && !calc_due)
                   || ((state == ST_ACC) && !last_frac);

  assign diff     = {1'b0, cnt_p} - {1'b0, cnt_g};
  assign span     = {1'b0, cnt_s} - {1'b0, cnt_g};
  assign diff_neg = diff[CNT_W];
  assign span_bad = span[CNT_W] || (span == '0);
  assign div_num  = (span_bad || diff_neg) ? '0 : {diff[CNT_W-1:0], {FRAC_SHIFT{1'b0}}};
  assign div_den  = span_bad ? CNT_W'(1) : span[CNT_W-1:0];
  assign norm     = norm_of(quotient, neg_r, bad_r);

  assign src_sel  = src_code(src, pin_select(gain_r));
  assign result   = avg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      src         <= SRC_GND;
      ref_was_gnd <= 1'b1;
      pin_seen    <= 1'b0;
      cnt_g       <= '0;
      cnt_p       <= '0;
      cnt_s       <= '0;
      frac_cnt    <= '0;
      settle_r    <= '0;
      win_r       <= '0;
      avg_r       <= '0;
      gain_r      <= SEL_UNIT;
      ilv_r       <= 1'b0;
      neg_r       <= 1'b0;
      bad_r       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state       <= ST_RUN;
          src         <= SRC_GND;
          ref_was_gnd <= 1'b1;
          pin_seen    <= 1'b0;
          frac_cnt    <= '0;
          settle_r    <= settle_len;
          win_r       <= window_len;
          avg_r       <= avg_log2;
          gain_r      <= gain_code;
          ilv_r       <= interleave;
        end
        ST_RUN: if (win_done) begin
          case (src)
            SRC_GND: cnt_g <= ones_final;
            SRC_SUP: cnt_s <= ones_final;
            default: begin
              cnt_p    <= ones_final;
              pin_seen <= 1'b1;
            end
          endcase
          if (calc_due) begin
            state <= ST_LOAD;
          end else begin
            src <= src_nxt;
            if (src_nxt != SRC_PIN) ref_was_gnd <= (src_nxt == SRC_GND);
          end
        end
        ST_LOAD: begin
          neg_r    <= diff_neg;
          bad_r    <= span_bad;
          pin_seen <= 1'b0;
          state    <= ST_WAIT;
        end
        ST_WAIT: if (div_done) state <= ST_ACC;
        ST_ACC: begin
          frac_cnt <= frac_cnt + FCW'(1);
          if (last_frac) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_RUN;
            src   <= src_nxt;
            if (src_nxt != SRC_PIN) ref_was_gnd <= (src_nxt == SRC_GND);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  rsd_window #(.CW(CNT_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (win_go),
    .settle     (settle_r),
    .window     (win_r),
    .bit_in     (sd_bit),
    .running    (mod_en),
    .done       (win_done),
    .ones_final (ones_final)
  );

  rsd_divider #(.NW(DW), .VW(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == ST_LOAD),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (quotient)
  );

  rsd_avg #(.OW(OUT_W), .LW(AVG_LW)) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       ((state == ST_IDLE) && start),
    .add       (state == ST_ACC),
    .last      (last_frac),
    .value     (norm),
    .value_err (bad_r),
    .log2      (avg_r),
    .result    (avg_word),
    .err       (result_err),
    .valid     (result_valid)
  );

  // R8: modulator is stopped while a fraction is being computed
  a_r8_stopped_in_calc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD || state == ST_WAIT || state == ST_ACC) |-> !mod_en);

  // R3: the select code never moves while the modulator keeps running
  a_r3_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && $past(mod_en)) |-> $stable(src_sel));

  // R4: input windows always use a unity-or-higher gain code
  a_r4_pin_code: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_PIN) |-> (src_sel >= 3'b011));

  // R11: word settings are frozen once a word is under way
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state) != ST_IDLE)
      |-> ($stable(win_r) && $stable(settle_r) && $stable(gain_r) && $stable(ilv_r)));

  // R9: the strobe follows only the last accumulation of a word
  a_r9_valid_after_acc: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> ($past(state) == ST_ACC && state == ST_IDLE));

endmodule

// File: tb/sim_rsd_cal_seq.sv
module sim_rsd_cal_seq;
  localparam int CW   = 20;
  localparam int LW   = 3;
  localparam int POST = CW + 35;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          sd_bit;
  logic [2:0]    gain_code;
  logic          interleave;
  logic [CW-1:0] settle_len;
  logic [CW-1:0] window_len;
  logic [LW-1:0] avg_log2;
  wire  [2:0]    src_sel;
  wire           mod_en;
  wire  [23:0]   result;
  wire           result_err;
  wire           result_valid;

  int      vectors = 0;
  int      miscmp  = 0;
  bit      finished = 0;
  int      acc = 0;
  longint  meas_ones;
  int      m_settle, m_win;
  logic [2:0]  hold_sel = 3'b000;
  logic [23:0] last_res = '0;
  logic        last_err = 1'b0;

  always #10 clk = ~clk;

  rsd_cal_seq #(.CNT_W(CW), .AVG_LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sd_bit(sd_bit),
    .gain_code(gain_code), .interleave(interleave), .settle_len(settle_len),
    .window_len(window_len), .avg_log2(avg_log2), .src_sel(src_sel),
    .mod_en(mod_en), .result(result), .result_err(result_err),
    .result_valid(result_valid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock of the reference model, compared at the falling edge.
  task automatic tick(input logic [2:0] es, input bit een, input bit ev,
                      input bit meas, input int dens, input string tag);
    @(negedge clk);
    check(src_sel == es, tag, "src_sel", longint'(src_sel), longint'(es));
    check(mod_en == een, tag, "mod_en", longint'(mod_en), longint'(een));
    check(result_valid == ev, "R9", "result_valid", longint'(result_valid), longint'(ev));
    if (!ev)
      check(result == last_res && result_err == last_err, "R9", "held result",
            longint'({result_err, result}), longint'({last_err, last_res}));
    if (een) begin
      acc += dens;
      if (acc >= 1024) begin sd_bit = 1'b1; acc -= 1024; end
      else sd_bit = 1'b0;
    end else begin
      sd_bit = 1'b1;
    end
    if (meas) meas_ones += longint'(sd_bit);
  endtask

  task automatic src_window(input logic [2:0] es, input int dens, input string tag,
                            output longint ones);
    meas_ones = 0;
    tick(es, 1'b0, 1'b0, 1'b0, dens, tag);
    repeat (m_settle) tick(es, 1'b1, 1'b0, 1'b0, dens, "R3");
    repeat (m_win)    tick(es, 1'b1, 1'b0, 1'b1, dens, tag);
    ones = meas_ones;
  endtask

  function automatic longint fracv(input longint g, input longint p, input longint s,
                                   output bit e);
    longint span, diff, q;
    span = s - g;
    diff = p - g;
    e = 1'b0;
    if (span <= 0) begin e = 1'b1; return 64'hFFFFFF; end
    if (diff < 0) return 0;
    q = ((diff << 32) / span) >> 8;
    if (q > 64'hFFFFFF) q = 64'hFFFFFF;
    return q;
  endfunction

  task automatic run_word(input bit ilv, input int st, input int wn, input int lg,
                          input int gain, input int dg, input int dp, input int ds,
                          input bit disturb);
    logic [2:0] ps;
    logic [2:0] rsel;
    longint g, p, s, sum, fv, expw;
    bit e, errw, ref_gnd;
    int n;
    ps = (gain >= 3) ? 3'(gain) : 3'b011;
    n = 1 << lg;
    m_settle = st;
    m_win = wn;
    interleave = ilv;
    settle_len = CW'(st);
    window_len = CW'(wn);
    avg_log2   = LW'(lg);
    gain_code  = 3'(gain);
    sum = 0; errw = 0; g = 0; p = 0; s = 0;
    tick(hold_sel, 1'b0, 1'b0, 1'b0, 0, "R1");
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (disturb) begin
      // R11: everything below is applied mid-word and must be ignored
      #1;
      start = 1'b1; gain_code = 3'b111; interleave = !ilv;
      settle_len = CW'(9); window_len = CW'(3); avg_log2 = '0;
    end
    rsel = 3'b001;
    if (!ilv) begin
      for (int k = 0; k < n; k++) begin
        src_window(3'b000, dg, disturb ? "R11" : "R2", g);
        src_window(ps, dp, "R4", p);
        src_window(3'b001, ds, "R2", s);
        fv = fracv(g, p, s, e);
        sum += fv; errw |= e;
        if (k == n - 1) start = 1'b0;
        repeat (POST) tick(3'b001, 1'b0, 1'b0, 1'b0, 0, "R8");
      end
    end else begin
      src_window(3'b000, dg, "R10", g);
      ref_gnd = 1'b1;
      for (int k = 0; k < n; k++) begin
        src_window(ps, dp, "R10", p);
        if (ref_gnd) begin
          src_window(3'b001, ds, "R10", s);
          rsel = 3'b001;
        end else begin
          src_window(3'b000, dg, "R10", g);
          rsel = 3'b000;
        end
        ref_gnd = !ref_gnd;
        fv = fracv(g, p, s, e);
        sum += fv; errw |= e;
        if (k == n - 1) start = 1'b0;
        repeat (POST) tick(rsel, 1'b0, 1'b0, 1'b0, 0, "R8");
      end
    end
    expw = sum >> lg;
    tick(rsel, 1'b0, 1'b1, 1'b0, 0, "R9");
    check(result == 24'(expw), errw ? "R6" : "R7", "result",
          longint'(result), expw);
    check(result_err == errw, "R6", "result_err", longint'(result_err), longint'(errw));
    last_res = 24'(expw);
    last_err = errw;
    hold_sel = rsel;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sd_bit = 1'b0; gain_code = 3'b011;
    interleave = 1'b0; settle_len = '0; window_len = '0; avg_log2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(src_sel == 3'b000, "R1", "src_sel", longint'(src_sel), 0);
    check(mod_en == 1'b0, "R1", "mod_en", longint'(mod_en), 0);
    check(result_valid == 1'b0, "R1", "result_valid", longint'(result_valid), 0);
    check(result == '0 && result_err == 1'b0, "R1", "result", longint'(result), 0);
    repeat (8) tick(3'b000, 1'b0, 1'b0, 1'b0, 0, "R1");
    run_word(1'b0, 4, 64, 2, 3, 300, 500, 800, 1'b0);   // R2 unity gain
    run_word(1'b0, 1, 100, 0, 6, 200, 600, 700, 1'b0);  // R4 gain code 110
    run_word(1'b0, 3, 50, 1, 1, 250, 900, 600, 1'b0);   // R4 fallback, R5 saturate high
    run_word(1'b0, 2, 40, 1, 5, 700, 500, 400, 1'b0);   // R6 inverted span
    run_word(1'b0, 2, 40, 1, 4, 500, 200, 800, 1'b0);   // R5 pin below ground
    run_word(1'b1, 3, 48, 3, 7, 150, 450, 850, 1'b0);   // R10 interleaved
    run_word(1'b0, 4, 32, 2, 3, 300, 420, 760, 1'b1);   // R11 normal, disturbed
    run_word(1'b1, 2, 30, 1, 2, 100, 333, 900, 1'b1);   // R11 interleaved, disturbed
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscmp++;
      $display("FAIL R1 watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

endmodule